// File: doc/BRIEF.md
# Sampling Clock Rate Monitor

This block lives in the bus-clock domain and watches a slower sampling clock that runs asynchronously to it. Each rising edge of the sampling clock flips a toggle bit. That toggle is carried into the bus domain through a synchronizer chain, and every change seen there counts as one sampling edge. A saturating counter measures how many bus cycles pass between sampling edges. If the counter reaches its limit, which is 32 bus cycles by default, the sampling clock is judged too slow. That is the case when its frequency is below one thirty-second of the bus clock.

The block has two outputs for this condition. A live status bit follows the condition and drops by itself once edges arrive at a healthy rate again. A sticky flag is raised on the same clock edge as the live bit and stays up until software writes a 0 to it. An interrupt contribution reflects the sticky flag while the generator is enabled.

Detection can be switched off with a control input. That input is captured only while the generator is off, so a change made while the generator runs has no effect until the next off period. A clock error never blocks or gates anything outside this block.

Top module: `sclk_rate_monitor`

## Requirements
- R1: After a synchronous reset, `rate_err`, `rate_err_sticky` and `irq_req` are all 0.
- R2: While enabled with detection on, a sampling clock whose edges are spaced fewer than `GAP_LIMIT` bus cycles apart never raises `rate_err`.
- R3: While enabled with detection on, a gap of `GAP_LIMIT` bus cycles with no sampling edge raises `rate_err`, and a stopped sampling clock keeps it at 1.
- R4: `rate_err` returns to 0 by itself within a few bus cycles once sampling edges arrive at a fast rate again.
- R5: `rate_err_sticky` rises on the same bus edge as `rate_err`. Only a 0-to-1 change of `rate_err` can set it, so it stays at 0 after a clear even while the error persists.
- R6: A write strobe (`flag_wr`=1) with `flag_wdata`=0 clears `rate_err_sticky`. A write strobe with `flag_wdata`=1 leaves it unchanged.
- R7: `det_off`=1 turns detection off, so `rate_err` stays 0. `det_off` is captured only while `gen_on`=0, and changes made while `gen_on`=1 are ignored.
- R8: While `gen_on`=0, the gap counter is held cleared and `rate_err` reads 0, but `rate_err_sticky` keeps its value.
- R9: `irq_req` is 1 exactly when `rate_err_sticky` is 1 and `gen_on` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_clk | input | 1 | Sampling clock, asynchronous to clk |
| gen_on | input | 1 | Generator enable |
| det_off | input | 1 | 1 turns rate detection off (captured while gen_on=0) |
| flag_wr | input | 1 | Single-cycle write strobe for the sticky flag |
| flag_wdata | input | 1 | Write value; 0 clears the sticky flag, 1 has no effect |
| rate_err | output | 1 | Live too-slow status |
| rate_err_sticky | output | 1 | Sticky too-slow flag |
| irq_req | output | 1 | Interrupt contribution |

## Verification
The bench builds the block with its defaults: `GAP_LIMIT`=32 and `SYNC_STAGES`=2. These let it drive sampling periods of 10 and 40 bus cycles, which sit well below and above the threshold. It also stops the sampling clock altogether to hold a steady error. With this limit, the error appears and clears within a few dozen cycles, so every transition of the live bit and the sticky flag can be reached quickly. That includes a clear during a persistent error and a change to the disable control while the generator is running.

// File: rtl/sclk_mon_pkg.sv
// Shared defaults and types for the sampling clock rate monitor.
package sclk_mon_pkg;
    // Bus cycles without a sampling edge that count as a too-slow clock.
    localparam int unsigned DEF_GAP_LIMIT   = 32;
    // Synchronizer depth for the toggle crossing.
    localparam int unsigned DEF_SYNC_STAGES = 2;

    // Error state held in the bus domain.
    typedef struct packed {
        logic live;
        logic sticky;
    } err_state_t;
endpackage

// File: rtl/sclk_toggle_sync.sv
// Turns each rising edge of the sampling clock into a one-cycle pulse in the
// bus clock domain. A toggle bit flips in the sampling domain, crosses through
// SYNC_STAGES flops, and a change at the end of the chain marks an edge.
// Assumes: SYNC_STAGES >= 2, and the sampling clock is slower than half
// the bus clock. rst_n is sampled by both domains; the sampling clock is
// expected to run during reset.
module sclk_toggle_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic samp_clk,
    output logic edge_pulse
);
    logic                   tgl_q;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    // Flip the toggle bit on every sampling-clock rising edge.
    always_ff @(posedge samp_clk) begin
        if (!rst_n) tgl_q <= 1'b0;
        else        tgl_q <= ~tgl_q;
    end

    // Synchronizer chain, one flop per stage.
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage samples the asynchronous toggle.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[0] <= 1'b0;
                else        sync_q[0] <= tgl_q;
            end
        end else begin : g_next
            // Later stages resolve metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[s] <= 1'b0;
                else        sync_q[s] <= sync_q[s-1];
            end
        end
    end

    // Keep the previous synchronized value for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[SYNC_STAGES-1];
    end

    assign edge_pulse = sync_q[SYNC_STAGES-1] ^ last_q;
endmodule

// File: rtl/sclk_gap_counter.sv
// Counts bus cycles since the last sampling edge and saturates at GAP_LIMIT.
// Assumes: run drops whenever detection must be inactive, which holds the
// count at zero.
module sclk_gap_counter #(
    parameter int unsigned GAP_LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic edge_seen,
    output logic at_limit
);
    localparam int unsigned CW = $clog2(GAP_LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(GAP_LIMIT);

    logic [CW-1:0] cnt_q;

    // Clear on an edge or while idle, otherwise count up to the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || edge_seen) cnt_q <= '0;
        else if (cnt_q != LIM)           cnt_q <= cnt_q + CW'(1);
    end

    assign at_limit = (cnt_q == LIM);

    // R3: the count never passes the limit.
    a_r3_cnt_capped: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM);
    // R8: an idle counter is empty on the next cycle.
    a_r8_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);
endmodule

// File: rtl/sclk_err_flags.sv
// Holds the live error status and the sticky flag. The sticky flag is set
// only when the live status goes from 0 to 1, on the same edge as the live
// status itself, and a write of 0 clears it.
// Assumes: slow_now is already forced to 0 while detection is inactive.
module sclk_err_flags
    import sclk_mon_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slow_now,
    input  logic       flag_wr,
    input  logic       flag_wdata,
    output err_state_t st
);
    err_state_t st_q;
    logic       rise;

    assign rise = slow_now & ~st_q.live;

    // Live status follows the condition and clears by itself.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q.live <= 1'b0;
        else        st_q.live <= slow_now;
    end

    // Sticky flag: a rising error sets it (this wins over a clear), a write of 0 clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                     st_q.sticky <= 1'b0;
        else if (rise)                  st_q.sticky <= 1'b1;
        else if (flag_wr && !flag_wdata) st_q.sticky <= 1'b0;
    end

    assign st = st_q;

    // R5: the sticky flag rises together with the live status.
    a_r5_sticky_with_live: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.live) |-> st_q.sticky);
    // R5: the sticky flag never rises without the live status rising.
    a_r5_sticky_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.sticky) |-> $rose(st_q.live));
    // R6: writing 1 keeps a set flag.
    a_r6_write_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr && flag_wdata && st_q.sticky |=> st_q.sticky);
    // R6: writing 0 during an ongoing error clears the flag.
    a_r6_write_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr && !flag_wdata && st_q.live |=> !st_q.sticky);
endmodule

// File: rtl/sclk_rate_monitor.sv
// Top of the sampling clock rate monitor. It detects a sampling clock slower
// than the bus clock divided by GAP_LIMIT and reports a live status, a sticky
// flag and an interrupt contribution.
// Assumes: det_off is meant to change only while gen_on is 0; it is captured
// only then.
module sclk_rate_monitor
    import sclk_mon_pkg::*;
#(
    parameter int unsigned GAP_LIMIT   = DEF_GAP_LIMIT,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic samp_clk,
    input  logic gen_on,
    input  logic det_off,
    input  logic flag_wr,
    input  logic flag_wdata,
    output logic rate_err,
    output logic rate_err_sticky,
    output logic irq_req
);
    logic       det_off_q;
    logic       run;
    logic       edge_pulse;
    logic       at_limit;
    err_state_t st;

    // Capture the disable control only while the generator is off.
    always_ff @(posedge clk) begin
        if (!rst_n)      det_off_q <= 1'b0;
        else if (!gen_on) det_off_q <= det_off;
    end

    assign run = gen_on & ~det_off_q;

    sclk_toggle_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .samp_clk   (samp_clk),
        .edge_pulse (edge_pulse)
    );

    sclk_gap_counter #(.GAP_LIMIT(GAP_LIMIT)) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .edge_seen (edge_pulse),
        .at_limit  (at_limit)
    );

    sclk_err_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .slow_now   (run & at_limit),
        .flag_wr    (flag_wr),
        .flag_wdata (flag_wdata),
        .st         (st)
    );

    assign rate_err        = st.live;
    assign rate_err_sticky = st.sticky;
    assign irq_req         = st.sticky & gen_on;

    // R7: the captured disable value holds while the generator runs.
    a_r7_capture_held: assert property (@(posedge clk) disable iff (!rst_n)
        gen_on && $past(gen_on) |-> $stable(det_off_q));
    // R8: a disabled generator shows no live error one cycle later.
    a_r8_off_no_live: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_on |=> !rate_err);
    // R4: a sampling edge clears the live error two cycles later.
    a_r4_edge_clears: assert property (@(posedge clk) disable iff (!rst_n)
        edge_pulse |=> ##1 !rate_err);
    // R9: the interrupt is never raised with the generator off.
    a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_on |-> !irq_req);
endmodule

// File: tb/sim_sclk_rate_monitor.sv
`timescale 1ns/1ps
module sim_sclk_rate_monitor;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic samp_clk = 1'b0;
    logic gen_on = 1'b0;
    logic det_off = 1'b0;
    logic flag_wr = 1'b0;
    logic flag_wdata = 1'b1;
    logic rate_err, rate_err_sticky, irq_req;

    int samp_half = 5;   // sampling half period in bus cycles; 0 stops it
    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    sclk_rate_monitor u0 (
        .clk(clk), .rst_n(rst_n), .samp_clk(samp_clk), .gen_on(gen_on),
        .det_off(det_off), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
        .rate_err(rate_err), .rate_err_sticky(rate_err_sticky), .irq_req(irq_req)
    );

    always #4 clk = ~clk;

    always begin
        if (samp_half == 0) #8;
        else begin
            #(samp_half * 8);
            samp_clk = ~samp_clk;
        end
    end

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_flag(logic v);
        @(negedge clk);
        flag_wr = 1'b1;
        flag_wdata = v;
        @(negedge clk);
        flag_wr = 1'b0;
        flag_wdata = 1'b1;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        wait_cyc(6);
        chk("R1", "rate_err in reset", rate_err, 1'b0);
        chk("R1", "sticky in reset", rate_err_sticky, 1'b0);
        chk("R1", "irq in reset", irq_req, 1'b0);
        rst_n = 1'b1;
        wait_cyc(2);
        chk("R1", "sticky after reset", rate_err_sticky, 1'b0);
    endtask

    task automatic t_fast;
        logic seen = 1'b0;
        det_off = 1'b0;
        wait_cyc(2);
        gen_on = 1'b1;
        samp_half = 5;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (rate_err) seen = 1'b1;
        end
        chk("R2", "error seen with fast clock", seen, 1'b0);
        chk("R2", "sticky with fast clock", rate_err_sticky, 1'b0);
    endtask

    task automatic t_slow;
        logic seen = 1'b0;
        samp_half = 20;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (rate_err && !seen) begin
                seen = 1'b1;
                chk("R5", "sticky at first live error", rate_err_sticky, 1'b1);
                chk("R9", "irq at first live error", irq_req, 1'b1);
            end
        end
        chk("R3", "error seen with slow clock", seen, 1'b1);
    endtask

    task automatic t_recover;
        samp_half = 5;
        wait_cyc(60);
        chk("R4", "live error after recovery", rate_err, 1'b0);
        chk("R5", "sticky held after recovery", rate_err_sticky, 1'b1);
        chk("R9", "irq with sticky set", irq_req, 1'b1);
    endtask

    task automatic t_clear;
        write_flag(1'b1);
        chk("R6", "sticky after write 1", rate_err_sticky, 1'b1);
        write_flag(1'b0);
        chk("R6", "sticky after write 0", rate_err_sticky, 1'b0);
        wait_cyc(50);
        chk("R6", "sticky stays clear", rate_err_sticky, 1'b0);
        chk("R9", "irq after clear", irq_req, 1'b0);
    endtask

    task automatic t_stopped;
        samp_half = 0;
        wait_cyc(60);
        chk("R3", "live error with stopped clock", rate_err, 1'b1);
        chk("R5", "sticky with stopped clock", rate_err_sticky, 1'b1);
        write_flag(1'b0);
        chk("R6", "sticky cleared during error", rate_err_sticky, 1'b0);
        wait_cyc(40);
        chk("R3", "live error persists", rate_err, 1'b1);
        chk("R5", "no re-set without new rise", rate_err_sticky, 1'b0);
    endtask

    task automatic t_gen_off;
        gen_on = 1'b0;
        wait_cyc(5);
        chk("R8", "live error with generator off", rate_err, 1'b0);
        gen_on = 1'b1;
        wait_cyc(60);
        chk("R3", "error after re-enable", rate_err, 1'b1);
        chk("R5", "sticky on new rise", rate_err_sticky, 1'b1);
        gen_on = 1'b0;
        wait_cyc(5);
        chk("R8", "live error off again", rate_err, 1'b0);
        chk("R8", "sticky kept while off", rate_err_sticky, 1'b1);
        chk("R9", "irq gated while off", irq_req, 1'b0);
    endtask

    task automatic t_disable;
        write_flag(1'b0);
        chk("R6", "sticky cleared while off", rate_err_sticky, 1'b0);
        det_off = 1'b1;
        wait_cyc(2);
        gen_on = 1'b1;
        wait_cyc(80);
        chk("R7", "no error with detection off", rate_err, 1'b0);
        chk("R7", "no sticky with detection off", rate_err_sticky, 1'b0);
        det_off = 1'b0;
        wait_cyc(80);
        chk("R7", "enable change ignored while on", rate_err, 1'b0);
        gen_on = 1'b0;
        wait_cyc(2);
        gen_on = 1'b1;
        wait_cyc(60);
        chk("R7", "detection on after capture", rate_err, 1'b1);
        det_off = 1'b1;
        wait_cyc(40);
        chk("R7", "disable change ignored while on", rate_err, 1'b1);
    endtask

    initial begin
        t_reset();
        t_fast();
        t_slow();
        t_recover();
        t_clear();
        t_stopped();
        t_gen_off();
        t_disable();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        wait (cyc >= 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule